// File: doc/BRIEF.md
# Cascadable Serial-to-Parallel Output Latch

This block turns a serial bit stream into a bank of parallel "sink on" controls for low-side loads. Bits enter on a serial input and move one position along an 8-stage shift chain on each rising edge of a shift clock. A separate latch clock copies the whole chain, in parallel, into a storage register. The storage register drives the outputs. While new data is being shifted in, the outputs keep showing the last latched pattern.

Two control pins are active low. The first is an asynchronous clear that empties the shift chain, the storage register and the cascade output all at once. The second is an output enable: while it is high, every output is held off.

The last stage of the chain is sent to a cascade output. That output is re-registered on the falling edge of the shift clock. A downstream copy of the block that shares the same clocks therefore gets half a clock period of extra hold time. Several copies can be chained this way to form a longer register.

Top module: `cascade_sink_latch`

## Requirements
- R1: On each rising edge of `shClk`, `serIn` is captured into stage 0 and every stage i moves into stage i+1. Stage 0 is the one nearest the serial input; stage 7 is the last stage.
- R2: On each rising edge of `latClk`, all stages are copied in parallel into the storage register. Edges of `shClk` alone never change `sinkOn`.
- R3: While `clrN` is low, the shift chain, the storage register and `serOut` are 0. The clear acts at once, without a clock edge, and overrides both clocks.
- R4: While `oeN` is high, `sinkOn` is all zeros, and the stored pattern is kept.
- R5: While `oeN` is low, `sinkOn[i]` equals storage bit i without any clock. A 1 means that output is sinking; a 0 means it is off.
- R6: `serOut` carries stage 7. It updates on the falling edge of `shClk`, so between a rising edge and the following falling edge it still shows the previous value.
- R7: When `shClk` and `latClk` rise on the same edge, the storage register captures the chain as it was before that shift.
- R8: Two copies chained through `serOut` into `serIn`, sharing both clocks, act as one 16-stage chain. After 16 shifts and one latch, the first copy holds the 8 newest bits and the second copy holds the 8 oldest.
- R9: After reset, `sinkOn` and `serOut` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| shClk | input | 1 | Shift clock; the chain advances on its rising edge |
| latClk | input | 1 | Latch clock; the storage register loads on its rising edge |
| clrN | input | 1 | Asynchronous clear, active low |
| oeN | input | 1 | Output enable, active low |
| serIn | input | 1 | Serial data input |
| sinkOn | output | 8 | Output controls; 1 means sinking (on) |
| serOut | output | 1 | Cascade output; stage 7 retimed to the falling edge of `shClk` |

## Verification
The hardest case to reach from the ports is both clocks rising on the same edge. The bench makes both clocks by gating one free-running clock with enables that change only while that clock is low. Raising both enables together therefore gives exactly coincident edges, and the latched value must then be the chain as it was before the shift.

The half-cycle retiming of `serOut` is checked by sampling it during the high phase after a shift, when it must still hold the old value, and again after the falling edge.

The clear is dropped between clock edges and checked without any clock. It is then held low while both clocks pulse with a 1 on `serIn`, and everything must stay at 0.

// File: rtl/cascade_sink_pkg.sv
package cascade_sink_pkg;
  // Strobes passed from the pin decoder to the datapath
  typedef struct packed {
    logic clearNow;   // asynchronous clear of all state
    logic drivePass;  // storage contents may reach the outputs
  } ctrlStrobes_t;
endpackage

// File: rtl/cascade_sink_ctrl.sv
module cascade_sink_ctrl
  import cascade_sink_pkg::*;
(
  input  logic         clrN,
  input  logic         oeN,
  output ctrlStrobes_t strb
);
  // Active-low pins become active-high strobes
  always_comb begin
    strb.clearNow  = ~clrN;
    strb.drivePass = ~oeN;
  end
endmodule

// File: rtl/cascade_sink_path.sv
module cascade_sink_path
  import cascade_sink_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             shClk,
  input  logic             latClk,
  input  ctrlStrobes_t     strb,
  input  logic             serIn,
  output logic [WIDTH-1:0] sinkOn,
  output logic             serOut
);
  localparam int LAST = WIDTH - 1;

  logic             clearNow;
  logic [WIDTH-1:0] shiftQ;
  logic [WIDTH-1:0] storeQ;
  logic             tapQ;

  assign clearNow = strb.clearNow;

  // Shift chain: stage 0 takes serIn, stage i feeds stage i+1
  always_ff @(posedge shClk or posedge clearNow) begin
    if (clearNow) shiftQ <= '0;
    else          shiftQ <= {shiftQ[LAST-1:0], serIn};
  end

  // Cascade tap, retimed to the falling edge for extra downstream hold
  always_ff @(negedge shClk or posedge clearNow) begin
    if (clearNow) tapQ <= 1'b0;
    else          tapQ <= shiftQ[LAST];
  end

  // Storage register: parallel copy of the chain
  always_ff @(posedge latClk or posedge clearNow) begin
    if (clearNow) storeQ <= '0;
    else          storeQ <= shiftQ;
  end

  // Output gating, one AND per output
  for (genvar i = 0; i < WIDTH; i++) begin : g_gate
    assign sinkOn[i] = strb.drivePass & storeQ[i];
  end

  assign serOut = tapQ;
endmodule

// File: rtl/cascade_sink_latch.sv
module cascade_sink_latch
  import cascade_sink_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             shClk,
  input  logic             latClk,
  input  logic             clrN,
  input  logic             oeN,
  input  logic             serIn,
  output logic [WIDTH-1:0] sinkOn,
  output logic             serOut
);
  ctrlStrobes_t strb;

  cascade_sink_ctrl u_ctrl (
    .clrN (clrN),
    .oeN  (oeN),
    .strb (strb)
  );

  cascade_sink_path #(.WIDTH(WIDTH)) u_path (
    .shClk  (shClk),
    .latClk (latClk),
    .strb   (strb),
    .serIn  (serIn),
    .sinkOn (sinkOn),
    .serOut (serOut)
  );
endmodule

// File: rtl/cascade_sink_chk.sv
module cascade_sink_chk #(
  parameter int WIDTH = 8
) (
  input logic             shClk,
  input logic             latClk,
  input logic             clrN,
  input logic             oeN,
  input logic             serIn,
  input logic [WIDTH-1:0] sinkOn,
  input logic             serOut,
  input logic [WIDTH-1:0] shiftQ,
  input logic [WIDTH-1:0] storeQ
);
  localparam int LAST = WIDTH - 1;

  // R1: chain moves by one position and takes serIn
  a_r1_shift_step: assert property (@(posedge shClk) disable iff (!clrN)
    1'b1 |=> (shiftQ[LAST:1] == $past(shiftQ[LAST-1:0])) && (shiftQ[0] == $past(serIn)));

  // R2, R7: storage holds the chain sampled at the latch edge (pre-shift if coincident)
  a_r2_parallel_load: assert property (@(posedge latClk) disable iff (!clrN)
    1'b1 |=> storeQ == $past(shiftQ));

  // R3: during clear, all state reads zero at any clock edge
  a_r3_clear_empty: assert property (@(posedge shClk) disable iff (clrN)
    1'b1 |-> (shiftQ == '0) && (storeQ == '0) && (serOut == 1'b0));

  // R4: disabled outputs are off
  a_r4_gate_off: assert property (@(posedge shClk) disable iff (!clrN)
    oeN |-> sinkOn == '0);

  // R5: enabled outputs show storage
  a_r5_pass: assert property (@(posedge shClk) disable iff (!clrN)
    !oeN |-> sinkOn == storeQ);

  // R6: at a rising edge serOut still shows last stage from the prior falling edge
  a_r6_tap_tracks: assert property (@(posedge shClk) disable iff (!clrN)
    1'b1 |-> serOut == shiftQ[LAST]);
endmodule

bind cascade_sink_latch cascade_sink_chk #(.WIDTH(WIDTH)) u_chk (
  .shClk  (shClk),
  .latClk (latClk),
  .clrN   (clrN),
  .oeN    (oeN),
  .serIn  (serIn),
  .sinkOn (sinkOn),
  .serOut (serOut),
  .shiftQ (u_path.shiftQ),
  .storeQ (u_path.storeQ)
);

// File: tb/sim_cascade_sink_latch.sv
`timescale 1ns/1ps
module sim_cascade_sink_latch;
  logic clk = 1'b0;
  logic shGate = 1'b0;
  logic latGate = 1'b0;
  logic clrN;
  logic oeN = 1'b0;
  logic serIn = 1'b0;
  logic shClk, latClk;
  logic [7:0] sinkA, sinkB;
  logic serA, serB;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz
  assign shClk  = clk & shGate;
  assign latClk = clk & latGate;

  cascade_sink_latch u0 (
    .shClk(shClk), .latClk(latClk), .clrN(clrN), .oeN(oeN),
    .serIn(serIn), .sinkOn(sinkA), .serOut(serA)
  );
  cascade_sink_latch u1 (
    .shClk(shClk), .latClk(latClk), .clrN(clrN), .oeN(oeN),
    .serIn(serA), .sinkOn(sinkB), .serOut(serB)
  );

  // Vectors: pattern (shifted bit 7 first), oeN, expected sinkOn
  typedef struct packed { logic [7:0] pat; logic oe; logic [7:0] exp; } vec_t;
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'hA5, 1'b0, 8'hA5},
    '{8'h3C, 1'b1, 8'h00},
    '{8'hFF, 1'b0, 8'hFF},
    '{8'h01, 1'b0, 8'h01},
    '{8'h80, 1'b0, 8'h80},
    '{8'h00, 1'b0, 8'h00}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at negedge+1; returns at the next negedge+1
  task automatic tick(input logic sh, input logic lat, input logic d);
    shGate = sh; latGate = lat; serIn = d;
    @(negedge clk); #1;
    shGate = 1'b0; latGate = 1'b0;
  endtask

  task automatic shiftByte(input logic [7:0] p);
    for (int i = 7; i >= 0; i--) tick(1'b1, 1'b0, p[i]);
  endtask

  initial begin
    logic [7:0] prevOut;
    logic [15:0] word;
    clrN = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R9 / R3: reset state
    chk("R9 reset sinkOn", {sinkB, sinkA}, 16'h0000);
    chk("R9 reset serOut", {15'd0, serA}, 16'h0000);
    clrN = 1'b1;
    tick(1'b0, 1'b0, 1'b0);

    // Table walk: R1, R2, R4, R5, R6
    prevOut = 8'h00;
    foreach (VECS[k]) begin
      oeN = VECS[k].oe;
      shiftByte(VECS[k].pat);
      chk("R2 shift leaves outputs", {8'h00, sinkA}, {8'h00, (VECS[k].oe ? 8'h00 : prevOut)});
      chk("R6 serOut last stage", {15'd0, serA}, {15'd0, VECS[k].pat[7]});
      tick(1'b0, 1'b1, 1'b0);
      chk("R1 R5 R4 latched pattern", {8'h00, sinkA}, {8'h00, VECS[k].exp});
      prevOut = VECS[k].pat;
    end
    oeN = 1'b0;

    // R4 retains storage: latch 5A, disable, re-enable
    shiftByte(8'h5A);
    tick(1'b0, 1'b1, 1'b0);
    oeN = 1'b1; #1;
    chk("R4 disabled off", {8'h00, sinkA}, 16'h0000);
    oeN = 1'b0; #1;
    chk("R5 re-enabled no clock", {8'h00, sinkA}, 16'h005A);

    // R6 half-cycle retiming: chain 7F, stage 7 = 0, next shift makes it 1
    shiftByte(8'h7F);
    chk("R6 before", {15'd0, serA}, 16'h0000);
    shGate = 1'b1; serIn = 1'b0;
    @(posedge clk); #1;
    chk("R6 held in high phase", {15'd0, serA}, 16'h0000);
    @(negedge clk); #1;
    shGate = 1'b0;
    chk("R6 updated after fall", {15'd0, serA}, 16'h0001);

    // R7 coincident edges: chain 96, shift 1 and latch together
    shiftByte(8'h96);
    tick(1'b1, 1'b1, 1'b1);
    chk("R7 pre-shift captured", {8'h00, sinkA}, 16'h0096);
    tick(1'b0, 1'b1, 1'b0);
    chk("R7 post-shift value", {8'h00, sinkA}, 16'h002D);

    // R8 cascade of two copies, 16 bits
    word = 16'hC3A5;
    for (int i = 15; i >= 0; i--) tick(1'b1, 1'b0, word[i]);
    tick(1'b0, 1'b1, 1'b0);
    chk("R8 first copy newest bits", {8'h00, sinkA}, {8'h00, word[7:0]});
    chk("R8 second copy oldest bits", {8'h00, sinkB}, {8'h00, word[15:8]});
    chk("R8 second copy serOut", {15'd0, serB}, {15'd0, word[15]});

    // R3 asynchronous clear, no clock
    shiftByte(8'hFF);
    tick(1'b0, 1'b1, 1'b0);
    chk("R3 setup FF", {8'h00, sinkA}, 16'h00FF);
    clrN = 1'b0; #1;
    chk("R3 async clear outputs", {sinkB, sinkA}, 16'h0000);
    chk("R3 async clear serOut", {14'd0, serB, serA}, 16'h0000);
    // R3 priority over both clocks
    tick(1'b1, 1'b1, 1'b1);
    tick(1'b1, 1'b1, 1'b1);
    chk("R3 clear beats clocks", {sinkB, sinkA}, 16'h0000);
    clrN = 1'b1;
    tick(1'b0, 1'b1, 1'b0);
    chk("R3 chain empty after clear", {sinkB, sinkA}, 16'h0000);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule